// File: doc/BRIEF.md
# Radix-4 Signed Array Multiplier

This block multiplies two two's-complement operands and delivers the full double-width signed product. It recodes the multiplier two bits at a time. Each pair of multiplier bits, read together with the bit just below the pair, picks one signed digit from {-2, -1, 0, +1, +2}. That digit selects a summand: zero, the multiplicand, or the multiplicand doubled, possibly negated. A 16-bit multiplier therefore needs only eight summands.

The summands are accumulated by a linear chain of rows. Each row adds its summand to the running partial product that arrives from the row above and passes the sum to the row below. After each row the two lowest bits of the running value are final. They are retired into the low half of the product, so every row works on a narrow window of constant width.

Each row's adder is built from 4-bit slices. A slice uses carry lookahead internally, and carries ripple from one slice to the next. A parameter inserts a pipeline register after every given number of rows. A value of zero makes the array purely combinational.

Top module: `bpr_mult`

## Requirements
- R1: `product_o` equals the exact 32-bit signed product of `mcand_i` and `mplier_i`, both read as 16-bit two's complement. This includes the extremes, such as -32768 × -32768 = 0x4000_0000 and 32767 × -32768 = 0xC000_8000.
- R2: For row r, the triplet (q[2r+1], q[2r], q[2r-1]) gives the digit: 000 → 0, 001 → +1, 010 → +1, 011 → +2, 100 → -2, 101 → -1, 110 → -1, 111 → 0. q[-1] is taken as 0.
- R3: There are eight rows. Row r adds digit × multiplicand × 4^r to the partial product it receives, and the row's result is exact.
- R4: Each row adder is made of 4-bit carry-lookahead slices with ripple between slices. A negative digit is formed by inverting the selected summand and injecting a carry of 1 into the lowest slice. Products whose carries cross every slice are exact.
- R5: With the default parameters there are two register stages (one after row 3 and one after row 7). Operands presented before a rising edge appear on `product_o` after the second rising edge. The output keeps the previous result after the first edge. A new operand pair is accepted every cycle.
- R6: When `rst_n` is low at a rising edge, all pipeline registers are cleared. `product_o` then reads 0 until operands sampled after reset has been released reach the output.
- R7: A zero multiplicand or a zero multiplier gives a product of 0, whatever the other operand is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| rst_n | input | 1 | Synchronous active-low reset |
| mcand_i | input | 16 | Multiplicand, two's complement |
| mplier_i | input | 16 | Multiplier, two's complement |
| product_o | output | 32 | Signed product, two's complement |

## Verification
The hardest situation to reach from the ports is a given digit landing in a given row. Only the full product is visible, so a wrong entry in one row's recoding can hide among the other rows. The stimulus therefore builds multipliers in which a single triplet is non-zero. It walks all eight triplet codes through all eight rows, which also covers the implicit zero below bit 0. Long streams of random operands fed one per cycle, plus the extreme values, then exercise the carry paths across slices and the stage registers under full throughput.

// File: rtl/bpr_pkg.sv
// Package: shared types for the radix-4 array multiplier.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package bpr_pkg;

    // Recoded digit: magnitude select plus sign
    typedef struct packed {
        logic neg;   // digit is negative
        logic one;   // magnitude 1
        logic two;   // magnitude 2
    } bpr_digit_t;

endpackage

// File: rtl/bpr_recode.sv
// Module: bpr_recode
// Turns one multiplier triplet (upper bit, lower bit, bit below) into a
// signed radix-4 digit. Assumes the caller supplies 0 for the bit below
// bit 0. The codes 000 and 111 both give zero with the sign cleared.
module bpr_recode
    import bpr_pkg::*;
(
    input  logic [2:0] trip_i,
    output bpr_digit_t dig_o
);

    // Decode the triplet into sign and magnitude selects
    always_comb begin
        dig_o.neg = trip_i[2] & ~(trip_i[1] & trip_i[0]);
        dig_o.one = trip_i[1] ^ trip_i[0];
        dig_o.two = (trip_i[2] & ~trip_i[1] & ~trip_i[0]) |
                    (~trip_i[2] & trip_i[1] & trip_i[0]);
    end

    // Guard: at most one magnitude select, and no negative zero (R2)
    always_comb begin
        p_sel_onehot_r2: assert ($onehot0({dig_o.one, dig_o.two}))
            else $error("recode: both magnitude selects active");
        p_no_neg_zero_r2: assert (!(dig_o.neg && !dig_o.one && !dig_o.two))
            else $error("recode: negative sign on zero digit");
    end

endmodule

// File: rtl/bpr_cla4.sv
// Module: bpr_cla4
// One adder slice of a row. Every internal carry is formed in lookahead
// form from the slice's generate/propagate terms and the carry in.
// Assumes W is small (default 4), since the lookahead terms grow as W^2.
module bpr_cla4 #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    logic [W-1:0] gen;
    logic [W-1:0] prop;
    logic [W:0]   carry;

    // Generate and propagate terms per bit
    always_comb begin
        gen  = a_i & b_i;
        prop = a_i ^ b_i;
    end

    // Lookahead carries: each carry expanded directly from gen/prop/cin
    always_comb begin
        logic term;
        logic cnext;
        carry[0] = cin_i;
        for (int i = 0; i < W; i++) begin
            term = cin_i;
            for (int j = 0; j <= i; j++) term = term & prop[j];
            cnext = term;
            for (int j = 0; j <= i; j++) begin
                term = gen[j];
                for (int k = j + 1; k <= i; k++) term = term & prop[k];
                cnext = cnext | term;
            end
            carry[i+1] = cnext;
        end
    end

    // Sum bits and slice carry out
    always_comb begin
        sum_o  = prop ^ carry[W-1:0];
        cout_o = carry[W];
    end

    // Guard: slice result matches plain addition (R4)
    always_comb begin
        p_slice_sum_r4: assert ({cout_o, sum_o} ==
                                ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
            else $error("slice: lookahead sum mismatch");
    end

endmodule

// File: rtl/bpr_row.sv
// Module: bpr_row
// One row of the array. It recodes its triplet and selects 0, M or 2M,
// inverting the summand and injecting a carry for negative digits. It then
// adds the summand to the incoming partial-product window through a chain
// of lookahead slices. Assumes AW >= N+2, so that +/-2M and the running
// value fit in the window without overflow.
module bpr_row
    import bpr_pkg::*;
#(
    parameter int N       = 16,
    parameter int SLICE_W = 4,
    parameter int CELLS   = 5,
    parameter int AW      = CELLS * SLICE_W
) (
    input  logic [AW-1:0] h_i,
    input  logic [N-1:0]  mc_i,
    input  logic [2:0]    trip_i,
    output logic [AW-1:0] sum_o
);

    bpr_digit_t         dig;
    logic [AW-1:0]      mx;
    logic [AW-1:0]      sel;
    logic [AW-1:0]      opnd;
    logic [CELLS:0]     cc;

    bpr_recode u_recode (
        .trip_i (trip_i),
        .dig_o  (dig)
    );

    // Sign-extend the multiplicand and pick the summand magnitude
    always_comb begin
        mx   = {{(AW-N){mc_i[N-1]}}, mc_i};
        sel  = dig.two ? (mx << 1) : (dig.one ? mx : '0);
        opnd = dig.neg ? ~sel : sel;
    end

    // Carry into the lowest slice completes the two's-complement negation
    assign cc[0] = dig.neg;

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        bpr_cla4 #(.W(SLICE_W)) u_cell (
            .a_i    (h_i[c*SLICE_W +: SLICE_W]),
            .b_i    (opnd[c*SLICE_W +: SLICE_W]),
            .cin_i  (cc[c]),
            .sum_o  (sum_o[c*SLICE_W +: SLICE_W]),
            .cout_o (cc[c+1])
        );
    end

    // Guard: row result equals incoming value plus digit times multiplicand (R3)
    always_comb begin
        logic signed [2:0]    dref;
        logic signed [AW-1:0] dext;
        logic signed [AW-1:0] mref;
        logic signed [AW-1:0] rref;
        logic                 top_c;
        unique case (trip_i)
            3'b001, 3'b010: dref = 3'sd1;
            3'b011:         dref = 3'sd2;
            3'b100:         dref = -3'sd2;
            3'b101, 3'b110: dref = -3'sd1;
            default:        dref = 3'sd0;
        endcase
        dext  = {{(AW-3){dref[2]}}, dref};
        mref  = $signed({{(AW-N){mc_i[N-1]}}, mc_i});
        rref  = $signed(h_i) + mref * dext;
        top_c = cc[CELLS];
        p_row_sum_r3: assert (sum_o == rref)
            else $error("row: sum mismatch (top carry %0b)", top_c);
    end

endmodule

// File: rtl/bpr_mult.sv
// Module: bpr_mult (top)
// Signed N x N multiplier built as a chain of N/2 recoded rows. Row r
// handles multiplier pair r. Its output window is shifted right by two, and
// its two lowest bits retire into the low half of the product. A register
// stage follows every PIPE_EVERY rows (0 = fully combinational). The
// operands travel with the data, so a new pair can enter every cycle.
// Assumes N is even.
module bpr_mult #(
    parameter int N          = 16,
    parameter int SLICE_W    = 4,
    parameter int PIPE_EVERY = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    mcand_i,
    input  logic [N-1:0]    mplier_i,
    output logic [2*N-1:0]  product_o
);

    localparam int ROWS  = N / 2;
    localparam int PW    = 2 * N;
    localparam int HW    = N + 2;
    localparam int CELLS = (HW + SLICE_W - 1) / SLICE_W;
    localparam int AW    = CELLS * SLICE_W;
    localparam int PDIV  = (PIPE_EVERY > 0) ? PIPE_EVERY : 1;

    // Chain between rows: window, retired bits, and operands carried along
    logic [AW-1:0] h_in [ROWS+1];
    logic [N-1:0]  lo   [ROWS+1];
    logic [N-1:0]  mc   [ROWS+1];
    logic [N:0]    mq   [ROWS+1];

    assign h_in[0] = '0;
    assign lo[0]   = '0;
    assign mc[0]   = mcand_i;
    assign mq[0]   = {mplier_i, 1'b0};

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [AW-1:0] row_sum;
        logic [AW-1:0] h_nx;
        logic [N-1:0]  lo_nx;

        bpr_row #(
            .N       (N),
            .SLICE_W (SLICE_W),
            .CELLS   (CELLS),
            .AW      (AW)
        ) u_row (
            .h_i    (h_in[r]),
            .mc_i   (mc[r]),
            .trip_i (mq[r][2*r +: 3]),
            .sum_o  (row_sum)
        );

        // Retire two settled bits and shift the window right by two
        always_comb begin
            h_nx = {{2{row_sum[AW-1]}}, row_sum[AW-1:2]};
            lo_nx = lo[r];
            lo_nx[2*r +: 2] = row_sum[1:0];
        end

        if ((PIPE_EVERY > 0) && (((r + 1) % PDIV) == 0)) begin : g_stage
            logic [AW-1:0] h_q;
            logic [N-1:0]  lo_q;
            logic [N-1:0]  mc_q;
            logic [N:0]    mq_q;

            // Stage register: clears on reset, otherwise captures the row outputs
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    h_q  <= '0;
                    lo_q <= '0;
                    mc_q <= '0;
                    mq_q <= '0;
                end else begin
                    h_q  <= h_nx;
                    lo_q <= lo_nx;
                    mc_q <= mc[r];
                    mq_q <= mq[r];
                end
            end

            assign h_in[r+1] = h_q;
            assign lo[r+1]   = lo_q;
            assign mc[r+1]   = mc_q;
            assign mq[r+1]   = mq_q;
        end else begin : g_pass
            assign h_in[r+1] = h_nx;
            assign lo[r+1]   = lo_nx;
            assign mc[r+1]   = mc[r];
            assign mq[r+1]   = mq[r];
        end
    end

    // Assemble the product: high half from the window, low half retired
    assign product_o = {h_in[ROWS][N-1:0], lo[ROWS]};

    // Guard: output equals the product of the operands that travelled with it (R1)
    always_comb begin
        logic signed [PW-1:0] pref;
        pref = $signed(mc[ROWS]) * $signed(mq[ROWS][N:1]);
        p_product_match_r1: assert (product_o == pref)
            else $error("top: product mismatch");
        p_high_sign_r1: assert (h_in[ROWS][AW-1:N] == {(AW-N){product_o[PW-1]}})
            else $error("top: window sign bits disagree with product sign");
    end

endmodule

// File: tb/bpr_mult_bench.sv
`timescale 1ns/1ps
module bpr_mult_bench;

    localparam int N   = 16;
    localparam int PW  = 2 * N;
    localparam int LAT = 2;

    logic          clk;
    logic          rst_n;
    logic [N-1:0]  a;
    logic [N-1:0]  b;
    logic [PW-1:0] prod;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [PW-1:0] exp_old;
    logic [PW-1:0] exp_new;

    bpr_mult u_bpr_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .mcand_i   (a),
        .mplier_i  (b),
        .product_o (prod)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Reference: signed product from the requirement definition
    function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        logic signed [PW-1:0] r;
        r = $signed(x) * $signed(y);
        return r;
    endfunction

    task automatic check(input logic [PW-1:0] act, input logic [PW-1:0] expv, input string tag);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, expv);
        end
    endtask

    // Present a pair and check it after the full latency
    task automatic mul_check(input logic [N-1:0] x, input logic [N-1:0] y, input string tag);
        @(negedge clk);
        a = x; b = y;
        repeat (LAT) @(negedge clk);
        check(prod, ref_mul(x, y), tag);
    endtask

    // Feed one pair per cycle; check the pair that entered LAT cycles earlier
    task automatic stream(input int count, input int mode);
        logic [N-1:0] x;
        logic [N-1:0] y;
        @(negedge clk);
        a = 16'h0101; b = 16'hFEFE;
        repeat (LAT) @(negedge clk);
        exp_old = ref_mul(a, b);
        exp_new = exp_old;
        for (int k = 0; k < count; k++) begin
            check(prod, exp_old, "R1/R5 stream");
            unique case (mode)
                0: begin x = N'($urandom); y = N'($urandom); end
                1: begin x = N'($urandom_range(0, 15)) - 16'd8; y = N'($urandom); end
                default: begin
                    x = ($urandom_range(0, 1) != 0) ? 16'h8000 : 16'h7FFF;
                    y = N'($urandom);
                end
            endcase
            exp_old = exp_new;
            exp_new = ref_mul(x, y);
            a = x; b = y;
            @(negedge clk);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        #1500000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        rst_n = 1'b0;
        a = 16'h1234; b = 16'h4321;

        // R6: reset clears the pipeline even with non-zero operands present
        repeat (3) @(negedge clk);
        check(prod, '0, "R6 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check(prod, '0, "R6 one edge after release");
        @(negedge clk);
        check(prod, ref_mul(16'h1234, 16'h4321), "R5 first result after release");

        // R1: extremes
        mul_check(16'h8000, 16'h8000, "R1 min*min");
        mul_check(16'h7FFF, 16'h8000, "R1 max*min");
        mul_check(16'h8000, 16'h7FFF, "R1 min*max");
        mul_check(16'h7FFF, 16'h7FFF, "R1 max*max");
        mul_check(16'h8001, 16'h7FFF, "R1 -max*max");
        mul_check(16'h8001, 16'h8001, "R1 -max*-max");

        // R7: zero operand gives zero
        mul_check(16'h0000, 16'h8000, "R7 zero multiplicand");
        mul_check(16'hBEEF, 16'h0000, "R7 zero multiplier");
        mul_check(16'h8000, 16'h0000, "R7 zero multiplier min mcand");

        // R4: carries crossing every slice, negative digits
        mul_check(16'hFFFF, 16'h0001, "R4 -1*1");
        mul_check(16'hFFFF, 16'hFFFF, "R4 -1*-1");
        mul_check(16'h7FFF, 16'hFFFF, "R4 max*-1");
        mul_check(16'h8000, 16'hFFFF, "R4 min*-1");
        mul_check(16'h1234, 16'hAAAA, "R4 alternating multiplier");
        mul_check(16'hF00D, 16'h5555, "R4 alternating multiplier 2");

        // R2/R3: a single non-zero triplet walked through every row and code
        for (int r = 0; r < 8; r++) begin
            for (int code = 0; code < 8; code++) begin
                logic [N-1:0] q;
                if (r == 0 && code[0]) continue;
                q = '0;
                q[2*r]   = code[1];
                q[2*r+1] = code[2];
                if (r > 0) q[2*r-1] = code[0];
                mul_check(16'hB3C5, q, $sformatf("R2/R3 row %0d code %0d", r, code));
                mul_check(16'h7FFF, q, $sformatf("R3 max mcand row %0d code %0d", r, code));
            end
        end

        // R5: output holds the previous result after one edge, updates after two
        @(negedge clk);
        a = 16'h0003; b = 16'h0005;
        repeat (LAT) @(negedge clk);
        a = 16'hFFF9; b = 16'h0011;
        @(negedge clk);
        check(prod, ref_mul(16'h0003, 16'h0005), "R5 hold after first edge");
        @(negedge clk);
        check(prod, ref_mul(16'hFFF9, 16'h0011), "R5 update after second edge");

        // R1/R5: random streams at full throughput
        stream(3000, 0);
        stream(500, 1);
        stream(500, 2);

        // R6: reset in mid-run clears the output
        @(negedge clk);
        a = 16'h7777; b = 16'h1357;
        rst_n = 1'b0;
        @(negedge clk);
        check(prod, '0, "R6 mid-run reset");
        @(negedge clk);
        check(prod, '0, "R6 held in reset");
        rst_n = 1'b1;
        repeat (LAT) @(negedge clk);
        check(prod, ref_mul(16'h7777, 16'h1357), "R6 recovery after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule